// File: doc/BRIEF.md
# Dual Latch-Based Down-Counter Timers

The block holds two 16-bit down-counters, each paired with a 16-bit reload latch. A processor reaches them through a byte-wide register port with a 4-bit address. The first timer either fires once per load or runs free, reloading itself from its latch. The second timer only fires once per load. Both counters step down by one on each clock cycle in which the tick-enable input is high, so that input sets the count rate.

When a timer expires, the block emits a one-cycle set pulse. Some register accesses emit a one-cycle clear pulse. Both kinds of pulse go to an interrupt flag unit outside this block, which holds the flags themselves.

A 16-bit value is loaded in two steps. Software first writes the low latch byte. It then writes the high byte to the address that starts the count. That write also copies the whole latch into the counter. A byte-wide mode register selects the first timer's operating mode.

Top module: `dual_latch_timer`

## Requirements
- R1: After reset, both latches and both counters hold 0xFFFF and the mode register reads 0x00. No set pulse appears until a timer has been loaded.
- R2: A write to address 0x4 or 0x6 changes only the low byte of the first timer's latch. The counter keeps its value.
- R3: A write to address 0x5 stores the latch high byte. From the next cycle the counter holds {written byte, latch low byte}. The write also produces a first-timer clear pulse (t1_clr) in the same cycle.
- R4: A write to address 0x7 stores the latch high byte and produces t1_clr. It does not reload the counter.
- R5: A read of 0x4 returns the counter low byte and produces t1_clr. A read of 0x5 returns the counter high byte and produces no clear pulse. Reads of 0x6 and 0x7 return the latch low and high bytes.
- R6: A counter changes only in cycles where tick_en is high or a load write occurs.
- R7: In one-shot mode, a set pulse appears in the tick cycle where the counter steps from 0x0000 to 0xFFFF. This happens at most once per load. Counting then continues through the wrap with no further pulse.
- R8: When mode bits [7:6] equal 2'b01, the first timer runs free. After 0xFFFF the next tick reloads the latch value, so set pulses recur every latch+2 ticks. Any other value of those bits selects one-shot.
- R9: For the second timer, a write to 0x8 changes only the latch low byte. A write to 0x9 stores the latch high byte, loads the counter and produces t2_clr. A read of 0x8 returns the counter low byte with t2_clr. A read of 0x9 returns the counter high byte. The second timer stays one-shot whatever the mode register holds.
- R10: The mode register at address 0xB can be written and read back as a whole byte.
- R11: If a loading write (0x5 or 0x9) falls in the same cycle as that timer's expiry tick, the load wins. The counter takes the latch value and no set pulse is emitted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count-rate enable; counters step when high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (its side effects are the clear pulses) |
| addr | input | 4 | Register address |
| wdata | input | BYTE_W | Write data |
| rdata | output | BYTE_W | Read data, combinational from addr |
| t1_set | output | 1 | First timer expiry pulse |
| t1_clr | output | 1 | First timer flag-clear request |
| t2_set | output | 1 | Second timer expiry pulse |
| t2_clr | output | 1 | Second timer flag-clear request |

## Verification
A vector table with ticks held off tries every register address with distinct byte values. This separates a low-latch write from a reload, a keep-latch high write from a loading one, and clearing reads from non-clearing ones.

Counting runs then cover three cases:
- a one-shot load of 5, where a single pulse at the sixth sample distinguishes one-shot from free-running;
- a free-running load of 3, where pulses spaced five ticks apart confirm the latch+2 period;
- the second timer with free-run selected, which must still fire only once.

A final case puts a load write on the expiry tick to confirm that the load takes priority.

// File: rtl/dlt_pkg.sv
package dlt_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    OFS_T1_CNT_LO = 4'h4,
    OFS_T1_CNT_HI = 4'h5,
    OFS_T1_LAT_LO = 4'h6,
    OFS_T1_LAT_HI = 4'h7,
    OFS_T2_CNT_LO = 4'h8,
    OFS_T2_CNT_HI = 4'h9,
    OFS_MODE      = 4'hB
  } reg_ofs_e;

  // decoded access strobes, one set per bus cycle
  typedef struct packed {
    logic t1_lo_wr;
    logic t1_hi_load;
    logic t1_hi_keep;
    logic t2_lo_wr;
    logic t2_hi_load;
    logic mode_wr;
    logic t1_clr;
    logic t2_clr;
  } strobes_t;

  localparam logic [1:0] MODE_FREE_RUN = 2'b01;
endpackage

// File: rtl/dlt_bus_decode.sv
module dlt_bus_decode
  import dlt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output strobes_t          stb
);

  always_comb begin
    stb = '0;
    if (wr_en) begin
      case (addr)
        OFS_T1_CNT_LO, OFS_T1_LAT_LO: stb.t1_lo_wr   = 1'b1;
        OFS_T1_CNT_HI:                stb.t1_hi_load = 1'b1;
        OFS_T1_LAT_HI:                stb.t1_hi_keep = 1'b1;
        OFS_T2_CNT_LO:                stb.t2_lo_wr   = 1'b1;
        OFS_T2_CNT_HI:                stb.t2_hi_load = 1'b1;
        OFS_MODE:                     stb.mode_wr    = 1'b1;
        default: ;
      endcase
    end
    // flag-clear side effects of accesses
    stb.t1_clr = (wr_en && (addr == OFS_T1_CNT_HI || addr == OFS_T1_LAT_HI)) ||
                 (rd_en && addr == OFS_T1_CNT_LO);
    stb.t2_clr = (wr_en && addr == OFS_T2_CNT_HI) ||
                 (rd_en && addr == OFS_T2_CNT_LO);
  end

  // a single access never targets two storage elements (R2, R4, R9)
  assert_one_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb.t1_lo_wr, stb.t1_hi_load, stb.t1_hi_keep,
              stb.t2_lo_wr, stb.t2_hi_load, stb.mode_wr}));

endmodule

// File: rtl/dlt_down_counter.sv
module dlt_down_counter #(
  parameter int BYTE_W    = 8,
  parameter bit RELOAD_OK = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic [BYTE_W-1:0]   wdata,
  input  logic                lo_wr,
  input  logic                hi_load,
  input  logic                hi_keep,
  input  logic                free_req,
  output logic [2*BYTE_W-1:0] cnt_o,
  output logic [2*BYTE_W-1:0] latch_o,
  output logic                expire_o
);

  localparam int CNT_W = 2 * BYTE_W;
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] latch_q;
  logic             armed_q;
  logic             free_mode;
  logic             at_zero;

  // next counter value on a tick: reload after the -1 state when free-running
  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] cur,
                                                  input logic [CNT_W-1:0] lat,
                                                  input logic             fr);
    if (fr && cur == ALL_ONES) return lat;
    return cur - 1'b1;
  endfunction

  function automatic logic is_zero(input logic [CNT_W-1:0] cur);
    return cur == '0;
  endfunction

  assign free_mode = RELOAD_OK ? free_req : 1'b0;
  assign at_zero   = is_zero(cnt_q);
  assign expire_o  = tick && !hi_load && at_zero && (armed_q || free_mode);
  assign cnt_o     = cnt_q;
  assign latch_o   = latch_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= ALL_ONES;
      latch_q <= ALL_ONES;
      armed_q <= 1'b0;
    end else begin
      if (lo_wr) latch_q[BYTE_W-1:0] <= wdata;
      if (hi_load || hi_keep) latch_q[CNT_W-1:BYTE_W] <= wdata;
      if (hi_load) begin
        cnt_q   <= {wdata, latch_q[BYTE_W-1:0]};
        armed_q <= 1'b1;
      end else if (tick) begin
        cnt_q <= step_count(cnt_q, latch_q, free_mode);
        if (expire_o) armed_q <= 1'b0;
      end
    end
  end

  // a loading write leaves counter and latch equal on the next cycle
  assert_load_copies_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hi_load |=> cnt_o == latch_o);

  // without tick or load the counter holds
  assert_hold_without_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !hi_load) |=> $stable(cnt_o));

  // an expiry tick is the step from zero into the all-ones state
  assert_expiry_wraps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> cnt_o == ALL_ONES);

  // free-running: the all-ones state reloads the latch held before the tick
  assert_free_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !hi_load && free_mode && cnt_o == ALL_ONES) |=> cnt_o == $past(latch_o));

endmodule

// File: rtl/dual_latch_timer.sv
module dual_latch_timer
  import dlt_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [3:0]        addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              t1_set,
  output logic              t1_clr,
  output logic              t2_set,
  output logic              t2_clr
);

  localparam int CNT_W  = 2 * BYTE_W;
  localparam int MODE_H = BYTE_W - 1;

  strobes_t          stb;
  logic [BYTE_W-1:0] mode_q;
  logic              t1_free;
  logic [CNT_W-1:0]  t1_cnt, t1_lat, t2_cnt, t2_lat;

  dlt_bus_decode u_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .stb   (stb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)           mode_q <= '0;
    else if (stb.mode_wr) mode_q <= wdata;
  end

  assign t1_free = (mode_q[MODE_H -: 2] == MODE_FREE_RUN);

  dlt_down_counter #(.BYTE_W(BYTE_W), .RELOAD_OK(1'b1)) u_t1 (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_en),
    .wdata    (wdata),
    .lo_wr    (stb.t1_lo_wr),
    .hi_load  (stb.t1_hi_load),
    .hi_keep  (stb.t1_hi_keep),
    .free_req (t1_free),
    .cnt_o    (t1_cnt),
    .latch_o  (t1_lat),
    .expire_o (t1_set)
  );

  dlt_down_counter #(.BYTE_W(BYTE_W), .RELOAD_OK(1'b0)) u_t2 (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_en),
    .wdata    (wdata),
    .lo_wr    (stb.t2_lo_wr),
    .hi_load  (stb.t2_hi_load),
    .hi_keep  (1'b0),
    .free_req (1'b0),
    .cnt_o    (t2_cnt),
    .latch_o  (t2_lat),
    .expire_o (t2_set)
  );

  assign t1_clr = stb.t1_clr;
  assign t2_clr = stb.t2_clr;

  always_comb begin
    case (addr)
      OFS_T1_CNT_LO: rdata = t1_cnt[BYTE_W-1:0];
      OFS_T1_CNT_HI: rdata = t1_cnt[CNT_W-1:BYTE_W];
      OFS_T1_LAT_LO: rdata = t1_lat[BYTE_W-1:0];
      OFS_T1_LAT_HI: rdata = t1_lat[CNT_W-1:BYTE_W];
      OFS_T2_CNT_LO: rdata = t2_cnt[BYTE_W-1:0];
      OFS_T2_CNT_HI: rdata = t2_cnt[CNT_W-1:BYTE_W];
      OFS_MODE:      rdata = mode_q;
      default:       rdata = '0;
    endcase
  end

  // the second timer never reloads by itself: two expiries need a load between
  // them, and a load write never coincides with a pulse (R9, R11)
  assert_t2_no_pulse_on_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stb.t2_hi_load |-> !t2_set);

  // a pulse on the second timer is followed by a non-zero counter (R9)
  assert_t2_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    t2_set |=> t2_cnt != '0);

endmodule

// File: tb/test_dual_latch_timer.sv
`timescale 1ns/1ps
module test_dual_latch_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       t1_set, t1_clr, t2_set, t2_clr;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_latch_timer i_dual_latch_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .t1_set(t1_set), .t1_clr(t1_clr), .t2_set(t2_set), .t2_clr(t2_clr)
  );

  typedef struct packed {
    logic       is_wr;
    logic [3:0] a;
    logic [7:0] d;
    logic [7:0] exp_rd;
    logic [1:0] exp_clr;   // {t2_clr, t1_clr}
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 22;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 4'h6, 8'h34, 8'h00, 2'b00, 4'd2},   // R2 latch low via 0x6
    '{1'b0, 4'h6, 8'h00, 8'h34, 2'b00, 4'd5},   // R5 latch low readback
    '{1'b0, 4'h4, 8'h00, 8'hFF, 2'b01, 4'd2},   // R2 counter untouched, clears
    '{1'b1, 4'h4, 8'h12, 8'h00, 2'b00, 4'd2},   // R2 latch low via 0x4
    '{1'b0, 4'h6, 8'h00, 8'h12, 2'b00, 4'd2},
    '{1'b0, 4'h5, 8'h00, 8'hFF, 2'b00, 4'd5},   // R5 high read, no clear
    '{1'b1, 4'h7, 8'hAB, 8'h00, 2'b01, 4'd4},   // R4 keep-latch high, clears
    '{1'b0, 4'h7, 8'h00, 8'hAB, 2'b00, 4'd4},
    '{1'b0, 4'h5, 8'h00, 8'hFF, 2'b00, 4'd4},   // R4 no reload
    '{1'b1, 4'h5, 8'h56, 8'h00, 2'b01, 4'd3},   // R3 load
    '{1'b0, 4'h4, 8'h00, 8'h12, 2'b01, 4'd3},
    '{1'b0, 4'h5, 8'h00, 8'h56, 2'b00, 4'd3},
    '{1'b0, 4'h7, 8'h00, 8'h56, 2'b00, 4'd3},
    '{1'b1, 4'h8, 8'h9A, 8'h00, 2'b00, 4'd9},   // R9 t2 latch low only
    '{1'b0, 4'h8, 8'h00, 8'hFF, 2'b10, 4'd9},
    '{1'b1, 4'h9, 8'hBC, 8'h00, 2'b10, 4'd9},   // R9 t2 load
    '{1'b0, 4'h8, 8'h00, 8'h9A, 2'b10, 4'd9},
    '{1'b0, 4'h9, 8'h00, 8'hBC, 2'b00, 4'd9},
    '{1'b1, 4'hB, 8'hC5, 8'h00, 2'b00, 4'd10},  // R10 mode write
    '{1'b0, 4'hB, 8'h00, 8'hC5, 2'b00, 4'd10},
    '{1'b1, 4'hB, 8'h00, 8'h00, 2'b00, 4'd10},
    '{1'b0, 4'hB, 8'h00, 8'h00, 2'b00, 4'd10}
  };

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] d, input logic [1:0] clr, input string req);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    #1 chk(req, "clear pulses on write", {14'd0, t2_clr, t1_clr}, {14'd0, clr});
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, input logic [7:0] exp, input logic [1:0] clr, input string req);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 chk(req, "read data", {8'd0, rdata}, {8'd0, exp});
    chk(req, "clear pulses on read", {14'd0, t2_clr, t1_clr}, {14'd0, clr});
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin : main
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk); #1;
    chk("R1", "no t1 pulse", {15'd0, t1_set}, 16'd0);
    chk("R1", "no t2 pulse", {15'd0, t2_set}, 16'd0);
    bus_rd(4'h4, 8'hFF, 2'b01, "R1");
    bus_rd(4'h5, 8'hFF, 2'b00, "R1");
    bus_rd(4'h6, 8'hFF, 2'b00, "R1");
    bus_rd(4'h7, 8'hFF, 2'b00, "R1");
    bus_rd(4'h8, 8'hFF, 2'b10, "R1");
    bus_rd(4'h9, 8'hFF, 2'b00, "R1");
    bus_rd(4'hB, 8'h00, 2'b00, "R1");

    // register vectors, ticks off
    for (int i = 0; i < NVEC; i++) begin
      string rq;
      rq = $sformatf("R%0d", VECS[i].req);
      if (VECS[i].is_wr) bus_wr(VECS[i].a, VECS[i].d, VECS[i].exp_clr, rq);
      else               bus_rd(VECS[i].a, VECS[i].exp_rd, VECS[i].exp_clr, rq);
    end

    // R6 no ticks: counter holds
    repeat (5) @(negedge clk);
    bus_rd(4'h4, 8'h12, 2'b01, "R6");
    bus_rd(4'h5, 8'h56, 2'b00, "R6");

    // R7 one-shot load of 5: one pulse at tick 5 then wrap continues
    bus_wr(4'h6, 8'h05, 2'b00, "R7");
    bus_wr(4'h5, 8'h00, 2'b01, "R7");
    @(negedge clk); tick_en = 1'b1;
    for (int k = 0; k < 20; k++) begin
      #1 chk("R7", $sformatf("t1 pulse at tick %0d", k), {15'd0, t1_set}, {15'd0, (k == 5)});
      @(negedge clk);
    end
    tick_en = 1'b0;
    bus_rd(4'h4, 8'hF1, 2'b01, "R7");
    bus_rd(4'h5, 8'hFF, 2'b00, "R7");

    // R8 free-running load of 3: pulses every 5 ticks
    bus_wr(4'hB, 8'h40, 2'b00, "R8");
    bus_wr(4'h6, 8'h03, 2'b00, "R8");
    bus_wr(4'h5, 8'h00, 2'b01, "R8");
    @(negedge clk); tick_en = 1'b1;
    for (int k = 0; k < 20; k++) begin
      #1 chk("R8", $sformatf("t1 pulse at tick %0d", k), {15'd0, t1_set},
             {15'd0, (k >= 3 && (k - 3) % 5 == 0)});
      @(negedge clk);
    end
    tick_en = 1'b0;
    bus_rd(4'h4, 8'h03, 2'b01, "R8");
    bus_rd(4'h5, 8'h00, 2'b00, "R8");

    // R9 second timer one-shot even with free-run selected
    bus_wr(4'h8, 8'h02, 2'b00, "R9");
    bus_wr(4'h9, 8'h00, 2'b10, "R9");
    @(negedge clk); tick_en = 1'b1;
    for (int k = 0; k < 10; k++) begin
      #1 chk("R9", $sformatf("t2 pulse at tick %0d", k), {15'd0, t2_set}, {15'd0, (k == 2)});
      @(negedge clk);
    end
    tick_en = 1'b0;
    bus_rd(4'h8, 8'hF8, 2'b10, "R9");
    bus_rd(4'h9, 8'hFF, 2'b00, "R9");

    // R11 load write on the expiry tick wins
    bus_wr(4'h8, 8'h02, 2'b00, "R11");
    bus_wr(4'h9, 8'h00, 2'b10, "R11");
    bus_wr(4'h8, 8'h07, 2'b00, "R11");
    bus_rd(4'h8, 8'h02, 2'b10, "R11");
    @(negedge clk); tick_en = 1'b1;
    #1 chk("R11", "no pulse tick 0", {15'd0, t2_set}, 16'd0);
    @(negedge clk);
    #1 chk("R11", "no pulse tick 1", {15'd0, t2_set}, 16'd0);
    @(negedge clk);
    wr_en = 1'b1; addr = 4'h9; wdata = 8'h00;
    #1 chk("R11", "pulse suppressed by load", {15'd0, t2_set}, 16'd0);
    chk("R11", "clear on load", {15'd0, t2_clr}, 16'd1);
    @(posedge clk); #1 wr_en = 1'b0; tick_en = 1'b0;
    bus_rd(4'h8, 8'h07, 2'b10, "R11");
    bus_rd(4'h9, 8'h00, 2'b00, "R11");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule